// File: doc/BRIEF.md
# Victim Line Buffer

This block sits next to a direct-mapped first-level cache. It keeps a few lines that the primary cache has just thrown out. Any stored line can sit in any entry. Each entry holds a valid bit, the full block address (every address bit above the word offset) and the line data. A line enters only through the eviction port, when the primary cache discards it. Nothing is ever loaded straight from the next memory level.

After a primary miss, the cache controller presents the block address on the lookup port before it asks the next level for anything. Every stored block address is compared with the request at once. The answer comes back one cycle later. On a hit, the line goes out on the fill port toward the primary cache and its entry is released. If the primary cache displaces a line in the same cycle, that line drops straight into the released entry, so the two lines trade places. When the primary cache evicts a line and looks up that same block in the same cycle, the evicted line is handed back as a hit. A synchronous flush empties the buffer.

Top module: `victim_cache`

## Requirements
- R1: The entry count `ENTRIES` is a parameter from 4 to 16. Any block may occupy any entry. A lookup compares its block address with the stored address of every valid entry and hits if any of them matches.
- R2: One cycle after `lk_valid_i` is high, `rsp_valid_o` is high and `rsp_hit_o` gives the result. On a hit, `rsp_data_o` carries the stored line. A cycle with no request gives `rsp_valid_o` low in the following cycle.
- R3: An eviction that is not paired with a lookup hit or with forwarding goes into the lowest-numbered invalid entry while one exists. Every line already stored stays stored.
- R4: With every entry valid, an eviction overwrites the entry named by a rotating pointer, which then advances by one and wraps after `ENTRIES-1`. The pointer is 0 after reset and after a flush. It moves only on such an overwrite, so the oldest of the lines that filled the buffer leaves first.
- R5: A lookup hit releases the matching entry, so a repeated lookup of the same block misses.
- R6: On a lookup hit with a same-cycle eviction of a different block, the evicted line takes the released entry. It uses neither a free entry nor the rotating pointer.
- R7: An eviction and a lookup of the same block in one cycle give a hit whose data is the evicted data. Nothing is stored.
- R8: `flush_i` invalidates every entry in one cycle and resets the pointer. A same-cycle lookup misses and a same-cycle eviction is dropped.
- R9: After reset, no entry is valid, and `rsp_valid_o` and `fill_valid_o` are low.
- R10: `fill_valid_o` is high exactly when the response is a hit. In that cycle `fill_blk_o` and `fill_data_o` carry the requested block and its line. A miss leaves `fill_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all entries |
| ev_valid_i | input | 1 | Primary cache discards a line |
| ev_blk_i | input | BLK_W | Block address of the discarded line |
| ev_data_i | input | DATA_W | Data of the discarded line |
| lk_valid_i | input | 1 | Lookup request after a primary miss |
| lk_blk_i | input | BLK_W | Block address searched |
| rsp_valid_o | output | 1 | Lookup answer present |
| rsp_hit_o | output | 1 | Lookup found the block |
| rsp_data_o | output | DATA_W | Line data on a hit |
| fill_valid_o | output | 1 | Line returned to the primary cache |
| fill_blk_o | output | BLK_W | Block address of the returned line |
| fill_data_o | output | DATA_W | Data of the returned line |

## Verification
On every cycle, the assertions check that a lookup produces exactly one answer in the next cycle and that the fill port pulses only with a hit. They also check that a flush leaves every valid bit clear and makes a same-cycle lookup miss, that the buffer is empty after reset, and that a cycle without a lookup or flush never lowers the number of stored lines. The bench scenarios are the only place to show which line leaves when the buffer is full, that a swapped-in line reuses the released entry, that forwarded data is correct, and that the data returned matches the data evicted. A reference model runs alongside both directed and pseudo-random traffic to cover these.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int VC_MIN_ENTRIES = 4;
    localparam int VC_MAX_ENTRIES = 16;

    typedef enum logic [2:0] {
        VC_IDLE,
        VC_FLUSH,
        VC_FWD,
        VC_SWAP,
        VC_ALLOC
    } vc_act_e;

    // Priority order of the one action taken per cycle
    function automatic vc_act_e vc_decide(input logic flush,
                                          input logic fwd,
                                          input logic lk_hit,
                                          input logic ev);
        if (flush)       return VC_FLUSH;
        else if (fwd)    return VC_FWD;
        else if (lk_hit) return VC_SWAP;
        else if (ev)     return VC_ALLOC;
        else             return VC_IDLE;
    endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int N  = 8,
    parameter int AW = 22,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [AW-1:0] tags [N],
    input  logic [AW-1:0] key,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [N-1:0]  valid,
    input  logic          take,
    output logic [IW-1:0] slot,
    output logic          full
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;

    assign full = &valid;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IW'(i);
        end
    end

    assign slot = full ? ptr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr_q <= '0;
        end else if (take && full) begin
            ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
    import vc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int BLK_W   = 22,
    parameter int DATA_W  = 128,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              ev_valid_i,
    input  logic [BLK_W-1:0]  ev_blk_i,
    input  logic [DATA_W-1:0] ev_data_i,
    input  logic              lk_valid_i,
    input  logic [BLK_W-1:0]  lk_blk_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              fill_valid_o,
    output logic [BLK_W-1:0]  fill_blk_o,
    output logic [DATA_W-1:0] fill_data_o
);
    logic [ENTRIES-1:0] valid_q;
    logic [BLK_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];

    logic          store_hit;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] alloc_slot;
    logic          buf_full;
    logic          fwd;
    logic          answered;
    vc_act_e       act;

    vc_match #(.N(ENTRIES), .AW(BLK_W)) u_match (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (lk_blk_i),
        .hit   (store_hit),
        .idx   (hit_idx)
    );

    vc_alloc #(.N(ENTRIES)) u_alloc (
        .clk   (clk),
        .rst   (rst),
        .clear (act == VC_FLUSH),
        .valid (valid_q),
        .take  (act == VC_ALLOC),
        .slot  (alloc_slot),
        .full  (buf_full)
    );

    assign fwd      = lk_valid_i && ev_valid_i && (ev_blk_i == lk_blk_i);
    assign act      = vc_decide(flush_i, fwd, lk_valid_i && store_hit, ev_valid_i);
    assign answered = (act == VC_FWD) || (act == VC_SWAP);

    // Valid bits and response flags
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= '0;
            rsp_valid_o  <= 1'b0;
            rsp_hit_o    <= 1'b0;
            fill_valid_o <= 1'b0;
        end else begin
            rsp_valid_o  <= lk_valid_i;
            rsp_hit_o    <= answered;
            fill_valid_o <= answered;
            case (act)
                VC_FLUSH: valid_q <= '0;
                VC_SWAP:  if (!ev_valid_i) valid_q[hit_idx] <= 1'b0;
                VC_ALLOC: valid_q[alloc_slot] <= 1'b1;
                default:  ;
            endcase
        end
    end

    // Line storage
    always_ff @(posedge clk) begin
        if (act == VC_SWAP && ev_valid_i) begin
            tag_q[hit_idx]  <= ev_blk_i;
            data_q[hit_idx] <= ev_data_i;
        end else if (act == VC_ALLOC) begin
            tag_q[alloc_slot]  <= ev_blk_i;
            data_q[alloc_slot] <= ev_data_i;
        end
    end

    // Response payload
    always_ff @(posedge clk) begin
        fill_blk_o <= lk_blk_i;
        if (act == VC_FWD) begin
            rsp_data_o  <= ev_data_i;
            fill_data_o <= ev_data_i;
        end else if (act == VC_SWAP) begin
            rsp_data_o  <= data_q[hit_idx];
            fill_data_o <= data_q[hit_idx];
        end else begin
            rsp_data_o  <= '0;
            fill_data_o <= '0;
        end
    end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         flush_i,
    input logic         lk_valid_i,
    input logic         rsp_valid_o,
    input logic         rsp_hit_o,
    input logic         fill_valid_o,
    input logic [N-1:0] valid_q
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid_i |=> rsp_valid_o);

    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid_i |=> !rsp_valid_o);

    p_hit_in_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit_o |-> rsp_valid_o);

    p_fill_pairs_hit_r10: assert property (@(posedge clk) disable iff (rst)
        fill_valid_o == rsp_hit_o);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (valid_q == '0));

    p_flush_miss_r8: assert property (@(posedge clk) disable iff (rst)
        (flush_i && lk_valid_i) |=> !rsp_hit_o);

    p_no_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && !lk_valid_i) |=> ($countones(valid_q) >= $countones($past(valid_q))));

    p_reset_empty_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0 && !rsp_valid_o && !fill_valid_o));
endmodule

bind victim_cache vc_checker #(.N(ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .lk_valid_i   (lk_valid_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_hit_o    (rsp_hit_o),
    .fill_valid_o (fill_valid_o),
    .valid_q      (valid_q)
);

// File: tb/sim_victim_cache.sv
module sim_victim_cache;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush_i = 1'b0;
    logic          ev_valid_i = 1'b0;
    logic [AW-1:0] ev_blk_i = '0;
    logic [DW-1:0] ev_data_i = '0;
    logic          lk_valid_i = 1'b0;
    logic [AW-1:0] lk_blk_i = '0;
    logic          rsp_valid_o, rsp_hit_o, fill_valid_o;
    logic [DW-1:0] rsp_data_o, fill_data_o;
    logic [AW-1:0] fill_blk_o;

    always #5 clk = ~clk;

    victim_cache #(.ENTRIES(N), .BLK_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .ev_valid_i(ev_valid_i), .ev_blk_i(ev_blk_i), .ev_data_i(ev_data_i),
        .lk_valid_i(lk_valid_i), .lk_blk_i(lk_blk_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_data_o(rsp_data_o),
        .fill_valid_o(fill_valid_o), .fill_blk_o(fill_blk_o), .fill_data_o(fill_data_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int gen = 0;

    // Reference model of the stored contents
    bit            mv [N];
    logic [AW-1:0] mt [N];
    logic [DW-1:0] md [N];
    int            mptr = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mkdata(input logic [AW-1:0] b);
        gen++;
        return {b, 10'(gen * 7 + 3)};
    endfunction

    function automatic bit present(input logic [AW-1:0] b);
        for (int i = 0; i < N; i++) if (mv[i] && mt[i] == b) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(input bit evv, input logic [AW-1:0] evb, input bit lkv,
                        input logic [AW-1:0] lkb, input bit fl, input string tag);
        logic [DW-1:0] evd;
        bit exp_hit;
        logic [DW-1:0] exp_data;
        int j;
        evd = mkdata(evb);
        exp_hit = 1'b0;
        exp_data = '0;
        if (fl) begin
            for (int i = 0; i < N; i++) mv[i] = 1'b0;
            mptr = 0;
        end else if (lkv && evv && evb == lkb) begin
            exp_hit = 1'b1;
            exp_data = evd;
        end else begin
            j = -1;
            if (lkv) for (int i = N - 1; i >= 0; i--) if (mv[i] && mt[i] == lkb) j = i;
            if (j >= 0) begin
                exp_hit = 1'b1;
                exp_data = md[j];
                if (evv) begin mt[j] = evb; md[j] = evd; end
                else mv[j] = 1'b0;
            end else if (evv) begin
                j = -1;
                for (int i = N - 1; i >= 0; i--) if (!mv[i]) j = i;
                if (j < 0) begin j = mptr; mptr = (mptr + 1) % N; end
                mv[j] = 1'b1; mt[j] = evb; md[j] = evd;
            end
        end
        @(negedge clk);
        ev_valid_i = evv; ev_blk_i = evb; ev_data_i = evd;
        lk_valid_i = lkv; lk_blk_i = lkb; flush_i = fl;
        @(posedge clk);
        #1;
        chk(rsp_valid_o == lkv, {tag, " R2 rsp_valid"}, 32'(rsp_valid_o), 32'(lkv));
        if (lkv) begin
            chk(rsp_hit_o == exp_hit, {tag, " hit"}, 32'(rsp_hit_o), 32'(exp_hit));
            if (exp_hit) begin
                chk(rsp_data_o == exp_data, {tag, " R2 data"}, 32'(rsp_data_o), 32'(exp_data));
                chk(fill_valid_o && fill_blk_o == lkb && fill_data_o == exp_data,
                    {tag, " R10 fill"}, {fill_valid_o, fill_blk_o, fill_data_o},
                    {1'b1, lkb, exp_data});
            end else begin
                chk(!fill_valid_o, {tag, " R10 no fill"}, 32'(fill_valid_o), 32'd0);
            end
        end
    endtask

    task automatic evict(input logic [AW-1:0] b, input string tag);
        step(1'b1, b, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic look(input logic [AW-1:0] b, input string tag);
        step(1'b0, '0, 1'b1, b, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        chk(!rsp_valid_o && !fill_valid_o, "R9 reset outputs", {rsp_valid_o, fill_valid_o}, 0);

        // R9 / R10: empty buffer misses everywhere
        for (int b = 0; b < 64; b++) look(AW'(b), "R9 empty sweep");

        // R1 / R5: fill then sweep all blocks twice
        for (int b = 10; b < 14; b++) evict(AW'(b), "R1 fill");
        for (int b = 0; b < 64; b++) look(AW'(b), "R1 sweep");
        for (int b = 0; b < 64; b++) look(AW'(b), "R5 resweep");

        // R4: overflow replaces oldest first
        for (int b = 20; b < 26; b++) evict(AW'(b), "R4 overflow");
        for (int b = 20; b < 26; b++) look(AW'(b), "R4 survivors");

        // R6: swap reuses released entry
        step(1'b0, '0, 1'b0, '0, 1'b1, "R8 flush");
        for (int b = 30; b < 34; b++) evict(AW'(b), "R6 fill");
        step(1'b1, 6'd40, 1'b1, 6'd31, 1'b0, "R6 swap");
        evict(6'd41, "R6 after swap");
        look(6'd30, "R6 oldest gone");
        look(6'd40, "R6 swapped line");
        look(6'd32, "R6 kept");
        look(6'd41, "R6 newest");

        // R7: forwarding
        step(1'b1, 6'd50, 1'b1, 6'd50, 1'b0, "R7 forward");
        look(6'd50, "R7 not stored");

        // R3: free slot preferred over pointer
        step(1'b0, '0, 1'b0, '0, 1'b1, "R8 flush");
        for (int b = 1; b < 5; b++) evict(AW'(b), "R3 fill");
        look(6'd2, "R3 release");
        evict(6'd5, "R3 refill");
        for (int b = 1; b < 6; b++) look(AW'(b), "R3 retained");

        // R8: flush with same-cycle traffic
        evict(6'd7, "R8 pre");
        evict(6'd8, "R8 pre");
        step(1'b1, 6'd9, 1'b1, 6'd7, 1'b1, "R8 flush busy");
        for (int b = 7; b < 10; b++) look(AW'(b), "R8 after flush");

        // R1: pseudo-random traffic against the model
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            bit evv, lkv, fl;
            logic [AW-1:0] evb, lkb;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            evv = lf[0];
            lkv = lf[1];
            fl  = (lf[9:2] == 8'h00);
            evb = AW'(lf[6:3]);
            lkb = AW'(lf[12:9]);
            if (evv && present(evb)) evv = 1'b0;
            step(evv, evb, lkv, lkb, fl, "R1 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule